// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a bus target for a two-wire serial bus. It gives an external master write and read access to a bank of 8-bit registers that sits outside the block. A fast system clock oversamples both bus lines. The block finds the start, repeated-start and stop conditions and compares the incoming address byte against a fixed address. One bit of that address comes from a strap input. The block acknowledges each byte it accepts.

A write transaction carries a register-pointer byte and then exactly one data byte. The data byte is passed to the register bank as a single-cycle strobe together with the pointer. A read first sets the pointer with a write. The master then issues a repeated start and sends the address with the read bit set. The block shifts out the contents of the pointed register, most significant bit first. The block only ever pulls the data line low or releases it, so the data line is open-drain.

Top module: `i2c_reg_target`

## Requirements
- R1: An address byte is acknowledged exactly when its bits 7:4 are 0110, bit 3 equals `strap_i` and bits 2:1 are 00. Bit 0 is the direction: 0 selects a write and 1 selects a read.
- R2: After an address byte that does not match, the block leaves SDA released, acknowledges nothing and raises no write strobe until the next start condition.
- R3: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start at any point restarts address reception. A stop at any point returns the block to idle with SDA released.
- R4: In a write, the byte after the address is taken as the register pointer and the next byte as data, both received MSB first. The block then pulses `wr_en` for one clock with `wr_ptr` and `wr_data` holding those two bytes.
- R5: During a write, the block holds SDA low through the ninth SCL pulse after the address byte, after the pointer byte and after the data byte.
- R6: A write carries a single data byte. Any further byte before the next start or stop is not acknowledged and does not raise `wr_en`.
- R7: After a repeated start with a matching address and the read bit set, the block acknowledges. It then drives `rd_data` for the pointer from the earlier write onto SDA, MSB first, one bit per SCL pulse. `rd_ptr` presents that pointer.
- R8: The block changes its SDA drive only while SCL is low.
- R9: After the read byte, the block releases SDA for the master's acknowledge bit and ignores the bus until the next start or stop. A following repeated start is served normally.
- R10: After reset, SDA is released, `wr_en` is low and `rd_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| strap_i | input | 1 | Strap value used for address bit 3 |
| sda_pull_low | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en | output | 1 | One-cycle write strobe to the register bank |
| wr_ptr | output | 8 | Register pointer for the write |
| wr_data | output | 8 | Data byte for the write |
| rd_ptr | output | 8 | Current register pointer for reads |
| rd_data | input | 8 | Register contents at `rd_ptr`, combinational |

## Verification
The hardest case to reach is the read path. Its data bits come from a pointer that an earlier transaction stored. They are driven only after a repeated start that arrives when no stop has been seen. The bench gets there with a write that carries only a pointer, a repeated start and a read-direction address. The register bank is a function of the pointer, so every pointer value reads back as a different pattern. After the read, a second repeated start opens a write, which shows that the post-read wait state is left correctly. An abandoned half byte ended by a stop, and a mismatched address followed by data bytes, cover the paths that must leave the bus untouched.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam logic [3:0] ADDR_UPPER = 4'b0110;
  localparam logic [1:0] ADDR_LOWER = 2'b00;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } tgt_state_t;

  // Address byte bits 7:1 compared against the fixed pattern with the strap in bit 3
  function automatic logic addr_hit(input logic [7:0] abyte, input logic strap);
    return abyte[7:1] == {ADDR_UPPER, strap, ADDR_LOWER};
  endfunction

endpackage

// File: rtl/tgt_line_sync.sv
module tgt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], line_i};
  end

  assign level_o = pipe[STAGES-1];
  assign rise_o  = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall_o  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/tgt_bus_cond.sv
module tgt_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_evt,
  output logic stop_evt
);
  assign start_evt = scl_lvl & sda_fall;
  assign stop_evt  = scl_lvl & sda_rise;

  // R3
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt}));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          strap_i,
  output logic          sda_pull_low,
  output logic          wr_en,
  output logic [DW-1:0] wr_ptr,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_ptr,
  input  logic [DW-1:0] rd_data
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_evt, stop_evt;

  tgt_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  tgt_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  tgt_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl),
    .sda_rise(sda_rise), .sda_fall(sda_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  tgt_state_t    state;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] rx_sh, tx_sh, ptr_q;
  logic          rw_q;
  logic          byte_end;

  assign byte_end = scl_fall && (bit_cnt == FULL);
  assign rd_ptr   = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      rx_sh        <= '0;
      tx_sh        <= '0;
      ptr_q        <= '0;
      rw_q         <= 1'b0;
      sda_pull_low <= 1'b0;
      wr_en        <= 1'b0;
      wr_ptr       <= '0;
      wr_data      <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_evt) begin
        state        <= ST_IDLE;
        sda_pull_low <= 1'b0;
      end else if (start_evt) begin
        state        <= ST_ADDR;
        bit_cnt      <= '0;
        sda_pull_low <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[DW-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_end) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit(rx_sh, strap_i)) begin
                  sda_pull_low <= 1'b1;
                  rw_q         <= rx_sh[0];
                  state        <= ST_ADDR_ACK;
                end else begin
                  state <= ST_WAIT;
                end
              end else if (state == ST_PTR) begin
                ptr_q        <= rx_sh;
                sda_pull_low <= 1'b1;
                state        <= ST_PTR_ACK;
              end else begin
                wr_en        <= 1'b1;
                wr_ptr       <= ptr_q;
                wr_data      <= rx_sh;
                sda_pull_low <= 1'b1;
                state        <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_q) begin
                sda_pull_low <= ~rd_data[DW-1];
                tx_sh        <= {rd_data[DW-2:0], 1'b0};
                state        <= ST_RDATA;
              end else begin
                sda_pull_low <= 1'b0;
                state        <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK: begin
            if (scl_fall) begin
              sda_pull_low <= 1'b0;
              state        <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_pull_low <= 1'b0;
              state        <= ST_WAIT;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_end) begin
              sda_pull_low <= 1'b0;
              state        <= ST_RACK;
            end else if (scl_fall) begin
              sda_pull_low <= ~tx_sh[DW-1];
              tx_sh        <= {tx_sh[DW-2:0], 1'b0};
            end
          end
          ST_RACK: begin
            if (scl_fall) state <= ST_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_low) |-> !$past(scl_lvl));

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R4
  wr_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> state == ST_WDATA_ACK);

  // R5
  ack_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK || state == ST_PTR_ACK || state == ST_WDATA_ACK) |-> sda_pull_low);

  // R3
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE && !sda_pull_low));

  // R3
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR && bit_cnt == '0));

  // R2
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT || state == ST_IDLE) |-> (!sda_pull_low && !wr_en));
endmodule

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
  localparam int Q = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       strap = 1'b0;
  logic       sda_pull_low, wr_en;
  logic [7:0] wr_ptr, wr_data, rd_ptr, rd_data;
  logic       sda_line;

  int checks = 0;
  int fails = 0;
  int wr_cnt = 0;
  logic [7:0] cap_ptr = '0, cap_data = '0;
  int viol = 0;
  logic prev_drive = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull_low;
  assign rd_data  = rd_ptr ^ 8'hA5;

  i2c_reg_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .sda_pull_low(sda_pull_low), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .rd_ptr(rd_ptr), .rd_data(rd_data));

  always @(posedge clk) begin
    if (wr_en) begin
      wr_cnt   <= wr_cnt + 1;
      cap_ptr  <= wr_ptr;
      cap_data <= wr_data;
    end
    if (rst_n && sda_pull_low != prev_drive && scl) viol <= viol + 1;
    prev_drive <= sda_pull_low;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;  tick(Q);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    ack = !sda_line;
    tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic read_byte(output logic [7:0] d, input bit master_ack);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      d = {d[6:0], sda_line};
      tick(Q);
      scl = 1'b0;   tick(Q);
    end
    send_bit(!master_ack);
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [7:0] p, input logic [7:0] d);
    bit a0, a1, a2;
    int base = wr_cnt;
    bus_start();
    send_byte(addr, a0);
    send_byte(p, a1);
    send_byte(d, a2);
    bus_stop();
    tick(4);
    chk(a0, "R1 addr ack", a0, 1);
    chk(a1 && a2, "R5 ptr/data ack", {a1, a2}, 3);
    chk(wr_cnt == base + 1, "R4 strobe count", wr_cnt - base, 1);
    chk(cap_ptr == p && cap_data == d, "R4 ptr/data", {cap_ptr, cap_data}, {p, d});
  endtask

  task automatic t_reset();
    chk(!sda_pull_low, "R10 sda released", sda_pull_low, 0);
    chk(!wr_en, "R10 wr_en low", wr_en, 0);
    chk(rd_ptr == 8'h00, "R10 rd_ptr", rd_ptr, 0);
  endtask

  task automatic t_write_strap0();
    strap = 1'b0; tick(Q);
    do_write(8'h60, 8'h3C, 8'hA7);
  endtask

  task automatic t_write_strap1();
    strap = 1'b1; tick(Q);
    do_write(8'h68, 8'h81, 8'h5A);
  endtask

  task automatic t_mismatch();
    bit a0, a1, a2;
    int base = wr_cnt;
    strap = 1'b0; tick(Q);
    bus_start();
    send_byte(8'h68, a0);
    send_byte(8'h11, a1);
    send_byte(8'h22, a2);
    chk(!sda_pull_low, "R2 sda released", sda_pull_low, 0);
    bus_stop(); tick(4);
    chk(!a0, "R1 strap mismatch nack", a0, 0);
    chk(!a1 && !a2, "R2 no ack after mismatch", {a1, a2}, 0);
    chk(wr_cnt == base, "R2 no strobe", wr_cnt - base, 0);
    bus_start();
    send_byte(8'h62, a0);
    bus_stop(); tick(4);
    chk(!a0, "R1 low bits mismatch nack", a0, 0);
  endtask

  task automatic t_extra_byte();
    bit a0, a1, a2, a3;
    int base = wr_cnt;
    strap = 1'b1; tick(Q);
    bus_start();
    send_byte(8'h68, a0);
    send_byte(8'h10, a1);
    send_byte(8'h77, a2);
    send_byte(8'h99, a3);
    bus_stop(); tick(4);
    chk(a0 && a1 && a2, "R5 acks before extra", {a0, a1, a2}, 7);
    chk(!a3, "R6 extra byte nack", a3, 0);
    chk(wr_cnt == base + 1, "R6 one strobe", wr_cnt - base, 1);
    chk(cap_data == 8'h77, "R6 data kept", cap_data, 8'h77);
  endtask

  task automatic t_read();
    bit a0, a1, a2, a3, a4;
    logic [7:0] d;
    int base = wr_cnt;
    strap = 1'b0; tick(Q);
    bus_start();
    send_byte(8'h60, a0);
    send_byte(8'h47, a1);
    bus_start();
    send_byte(8'h61, a2);
    read_byte(d, 1'b0);
    chk(!sda_pull_low, "R9 released after read", sda_pull_low, 0);
    chk(a0 && a1 && a2, "R7 acks", {a0, a1, a2}, 7);
    chk(rd_ptr == 8'h47, "R7 rd_ptr", rd_ptr, 8'h47);
    chk(d == (8'h47 ^ 8'hA5), "R7 read data", d, 8'h47 ^ 8'hA5);
    bus_start();
    send_byte(8'h60, a3);
    send_byte(8'hC3, a4);
    send_byte(8'h0F, a4);
    bus_stop(); tick(4);
    chk(a3 && a4, "R9 write after read", {a3, a4}, 3);
    chk(wr_cnt == base + 1 && cap_ptr == 8'hC3, "R9 strobe after read", cap_ptr, 8'hC3);
    bus_start();
    send_byte(8'h61, a0);
    read_byte(d, 1'b0);
    bus_stop(); tick(4);
    chk(d == (8'hC3 ^ 8'hA5), "R7 read new ptr", d, 8'hC3 ^ 8'hA5);
  endtask

  task automatic t_stop_mid();
    bit a0;
    int base = wr_cnt;
    strap = 1'b0; tick(Q);
    bus_start();
    send_byte(8'h60, a0);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop(); tick(4);
    chk(wr_cnt == base && !sda_pull_low, "R3 stop mid byte", wr_cnt - base, 0);
    do_write(8'h60, 8'h05, 8'hE1);
  endtask

  initial begin
    tick(5);
    t_reset();
    rst_n = 1'b1;
    tick(5);
    t_write_strap0();
    t_write_strap1();
    t_mismatch();
    t_extra_byte();
    t_read();
    t_stop_mid();
    chk(viol == 0, "R8 drive changes while SCL low", viol, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule